// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns a stream of parallel pixels into the bit streams for a low-voltage differential display link. Each pixel holds 8-bit red, green and blue values and three control bits: horizontal sync, vertical sync and data enable. Every pixel period is sent as seven bit slots, in parallel, on four serial data lanes. A fifth lane carries a fixed clock pattern that marks where each frame starts. The block runs on one clock at the bit rate, and the electrical drivers sit downstream of it.

A static mode input selects how the color and control bits map onto the slots. Three mappings are available. The first is an 18-bit layout on three lanes that uses the six upper bits of each color. The second is a 24-bit layout whose fourth lane carries the two least significant bits of each color. The third is a 24-bit layout that places the six low bits on lanes 0 to 2 and the two top bits on lane 3. A mirror input reverses the slot order of every data lane. The block pulses `ready` once every seven cycles. The pixel, mode and mirror inputs present on the next clock edge are captured together, so a frame is always sent with the settings it started with.

Top module: `pix7_serializer`

## Requirements
- R1: `lane_clk` is 1 in slots 0, 1, 5 and 6 and 0 in slots 2, 3 and 4, whatever the mode and mirror are set to.
- R2: `ready` is high for exactly one cycle, during slot 6, so consecutive pulses are seven cycles apart.
- R3: With `map_mode`=2'b00, the slots 0..6 of each lane carry the following (Rn, Gn and Bn are bit n of the 8-bit inputs). Lane 0: G2, R7, R6, R5, R4, R3, R2. Lane 1: B3, B2, G7, G6, G5, G4, G3. Lane 2: DE, VS, HS, B7, B6, B5, B4. Lane 3 stays 0.
- R4: With `map_mode`=2'b01, lanes 0 to 2 carry what they carry in R3. Lane 3 carries 0, B1, B0, G1, G0, R1, R0 in slots 0..6.
- R5: With `map_mode`=2'b10, slots 0..6 carry the following. Lane 0: G0, R5..R0. Lane 1: B1, B0, G5..G1. Lane 2: DE, VS, HS, B5..B2. Lane 3: 0, B7, B6, G7, G6, R7, R6.
- R6: `map_mode`=2'b11 gives exactly the 2'b00 output.
- R7: Data enable, vertical sync and horizontal sync occupy slots 0, 1 and 2 of lane 2. Slot 0 of lane 3 is always 0.
- R8: With `mirror`=1, data lane bit k is sent in slot 6-k, and `lane_clk` is not reversed.
- R9: The inputs are sampled only on the edge that ends slot 6. Input changes at any other time have no effect on the frame being sent.
- R10: While `rst` is high (synchronous, active high), all data lanes are 0, `ready` is 0 and `lane_clk` is 1 (slot 0). The first frame after reset is all zeros.
- R11: In the 2'b00 mode, bits 1:0 of each color input have no effect on any lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_red | input | 8 | Red component |
| pix_grn | input | 8 | Green component |
| pix_blu | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| map_mode | input | 2 | Slot mapping select (00 and 11: 18-bit, 01 and 10: 24-bit variants) |
| mirror | input | 1 | Reverse slot order on data lanes |
| ready | output | 1 | High in slot 6: inputs are taken at the next edge |
| lane_data | output | 4 | Serial data lanes 3..0 |
| lane_clk | output | 1 | Clock-pattern lane |

## Verification
The inputs are driven at the falling edge where `ready` is seen high, and the rising edge that follows captures them. Slot k of that frame then appears on the lanes at the (k+1)-th falling edge after that capture edge, because both the counter and the captured pixel are registered, so each lane is sampled at those seven falling edges. The spacing between `ready` pulses is counted in falling edges and must be exactly seven, with `ready` low at the first one. Reset is checked one falling edge after `rst` rises, mid-frame. Freedom from corruption is checked by changing every input at slot 3 and confirming that the frame keeps its captured content.

// File: rtl/pix7_pkg.sv
package pix7_pkg;
   localparam int PIX_CW    = 8;
   localparam int PIX_SLOTS = 7;
   localparam int PIX_LANES = 4;

   typedef logic [PIX_SLOTS-1:0] slot_word_t;

   typedef enum logic [1:0] {
      MAP_NARROW = 2'b00,
      MAP_WIDE_A = 2'b01,
      MAP_WIDE_B = 2'b10,
      MAP_ALIAS  = 2'b11
   } map_e;

   typedef struct packed {
      logic [PIX_CW-1:0] red;
      logic [PIX_CW-1:0] grn;
      logic [PIX_CW-1:0] blu;
      logic              hs;
      logic              vs;
      logic              de;
   } pix_t;
endpackage

// File: rtl/pix7_slot_ctr.sv
module pix7_slot_ctr #(
   parameter int SLOTS = 7,
   localparam int SW   = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [SW-1:0] slot,
   output logic          wrap
);
   localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

   assign wrap = (slot == LAST);

   always_ff @(posedge clk) begin
      if (rst)       slot <= '0;
      else if (wrap) slot <= '0;
      else           slot <= slot + 1'b1;
   end
endmodule

// File: rtl/pix7_capture.sv
module pix7_capture
   import pix7_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  pix_t       pix_in,
   input  logic [1:0] mode_in,
   input  logic       mirror_in,
   output pix_t       pix_q,
   output logic [1:0] mode_q,
   output logic       mirror_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pix_q    <= '0;
         mode_q   <= MAP_NARROW;
         mirror_q <= 1'b0;
      end else if (load) begin
         pix_q    <= pix_in;
         mode_q   <= mode_in;
         mirror_q <= mirror_in;
      end
   end
endmodule

// File: rtl/pix7_lane_map.sv
module pix7_lane_map
   import pix7_pkg::*;
#(
   parameter int  SLOTS     = 7,
   parameter int  LANES     = 4,
   parameter bit  MIRROR_EN = 1'b1,
   localparam int SW        = $clog2(SLOTS)
) (
   input  pix_t             pix,
   input  logic [1:0]       mode,
   input  logic             mirror,
   input  logic [SW-1:0]    slot,
   output logic [LANES-1:0] lanes
);
   localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

   slot_word_t       words [LANES];
   logic [5:0]       r6, g6, b6;
   logic             low_sel;
   logic [SW-1:0]    idx;

   always_comb begin
      low_sel = (map_e'(mode) == MAP_WIDE_B);
      r6 = low_sel ? pix.red[5:0] : pix.red[7:2];
      g6 = low_sel ? pix.grn[5:0] : pix.grn[7:2];
      b6 = low_sel ? pix.blu[5:0] : pix.blu[7:2];

      words[0][0] = g6[0];
      for (int k = 1; k < SLOTS; k++) words[0][k] = r6[6-k];

      words[1][0] = b6[1];
      words[1][1] = b6[0];
      for (int k = 2; k < SLOTS; k++) words[1][k] = g6[7-k];

      words[2][0] = pix.de;
      words[2][1] = pix.vs;
      words[2][2] = pix.hs;
      for (int k = 3; k < SLOTS; k++) words[2][k] = b6[8-k];

      unique case (map_e'(mode))
         MAP_WIDE_A: words[3] = {pix.red[0], pix.red[1], pix.grn[0], pix.grn[1],
                                 pix.blu[0], pix.blu[1], 1'b0};
         MAP_WIDE_B: words[3] = {pix.red[6], pix.red[7], pix.grn[6], pix.grn[7],
                                 pix.blu[6], pix.blu[7], 1'b0};
         default:    words[3] = '0;
      endcase
   end

   generate
      if (MIRROR_EN) begin : g_rev
         assign idx = mirror ? (LAST - slot) : slot;
      end else begin : g_fwd
         assign idx = slot;
      end
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign lanes[l] = words[l][idx];
      end
   endgenerate
endmodule

// File: rtl/pix7_serializer.sv
module pix7_serializer
   import pix7_pkg::*;
#(
   parameter int COLOR_W   = 8,
   parameter int SLOTS     = 7,
   parameter int LANES     = 4,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [COLOR_W-1:0] pix_red,
   input  logic [COLOR_W-1:0] pix_grn,
   input  logic [COLOR_W-1:0] pix_blu,
   input  logic               pix_hs,
   input  logic               pix_vs,
   input  logic               pix_de,
   input  logic [1:0]         map_mode,
   input  logic               mirror,
   output logic               ready,
   output logic [LANES-1:0]   lane_data,
   output logic               lane_clk
);
   localparam int SW = $clog2(SLOTS);

   generate
      if (COLOR_W != PIX_CW) begin : g_bad_cw
         $error("pix7_serializer: COLOR_W must be 8");
      end
      if (SLOTS != PIX_SLOTS) begin : g_bad_slots
         $error("pix7_serializer: SLOTS must be 7");
      end
      if (LANES != PIX_LANES) begin : g_bad_lanes
         $error("pix7_serializer: LANES must be 4");
      end
   endgenerate

   logic [SW-1:0] slot_q;
   logic          wrap;
   pix_t          pix_in, cap_pix;
   logic [1:0]    cap_mode;
   logic          cap_mirror;

   assign pix_in = '{red: pix_red, grn: pix_grn, blu: pix_blu,
                     hs: pix_hs, vs: pix_vs, de: pix_de};

   pix7_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .slot (slot_q),
      .wrap (wrap)
   );

   pix7_capture u_cap (
      .clk       (clk),
      .rst       (rst),
      .load      (wrap),
      .pix_in    (pix_in),
      .mode_in   (map_mode),
      .mirror_in (mirror),
      .pix_q     (cap_pix),
      .mode_q    (cap_mode),
      .mirror_q  (cap_mirror)
   );

   pix7_lane_map #(
      .SLOTS     (SLOTS),
      .LANES     (LANES),
      .MIRROR_EN (MIRROR_EN)
   ) u_map (
      .pix    (cap_pix),
      .mode   (cap_mode),
      .mirror (cap_mirror),
      .slot   (slot_q),
      .lanes  (lane_data)
   );

   assign ready = wrap & ~rst;

   always_comb begin
      lane_clk = ~((slot_q >= SW'(2)) && (slot_q <= SW'(4)));
   end
endmodule

// File: rtl/pix7_serializer_chk.sv
module pix7_serializer_chk
   import pix7_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       ready,
   input logic       lane_clk,
   input logic [3:0] lane_data,
   input logic [2:0] slot,
   input logic [1:0] cap_mode,
   input logic       cap_mirror,
   input pix_t       cap_pix
);
   logic [2:0] since_rdy;

   always_ff @(posedge clk) begin
      if (rst || ready)          since_rdy <= '0;
      else if (since_rdy != 3'd7) since_rdy <= since_rdy + 1'b1;
   end

   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      ready |=> !ready); // R2

   AST_READY_PERIOD: assert property (@(posedge clk) disable iff (rst)
      ready |-> since_rdy == 3'd6); // R2

   AST_CLK_LANE_LOW: assert property (@(posedge clk) disable iff (rst)
      (slot >= 3'd2 && slot <= 3'd4) |-> !lane_clk); // R1

   AST_CLK_LANE_HIGH: assert property (@(posedge clk) disable iff (rst)
      ready |-> lane_clk); // R1

   AST_NARROW_LANE3_IDLE: assert property (@(posedge clk) disable iff (rst)
      (cap_mode == 2'b00 || cap_mode == 2'b11) |-> !lane_data[3]); // R3

   AST_CTL3_ZERO: assert property (@(posedge clk) disable iff (rst)
      (slot == (cap_mirror ? 3'd6 : 3'd0)) |-> !lane_data[3]); // R7

   AST_DE_SLOT: assert property (@(posedge clk) disable iff (rst)
      (slot == (cap_mirror ? 3'd6 : 3'd0)) |-> lane_data[2] == cap_pix.de); // R7

   AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (rst)
      !ready |=> $stable(cap_pix) && $stable(cap_mode) && $stable(cap_mirror)); // R9

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> lane_data == 4'b0000); // R10
endmodule

bind pix7_serializer pix7_serializer_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .ready      (ready),
   .lane_clk   (lane_clk),
   .lane_data  (lane_data),
   .slot       (slot_q),
   .cap_mode   (cap_mode),
   .cap_mirror (cap_mirror),
   .cap_pix    (cap_pix)
);

// File: tb/pix7_serializer_tb.sv
module pix7_serializer_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] red = '0, grn = '0, blu = '0;
   logic       hs = 1'b0, vs = 1'b0, de = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       mir = 1'b0;
   logic       ready, lane_clk;
   logic [3:0] lane_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pix7_serializer u_dut (
      .clk(clk), .rst(rst), .pix_red(red), .pix_grn(grn), .pix_blu(blu),
      .pix_hs(hs), .pix_vs(vs), .pix_de(de), .map_mode(mode), .mirror(mir),
      .ready(ready), .lane_data(lane_data), .lane_clk(lane_clk)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected lane words {lane3,lane2,lane1,lane0}, each bit index = slot
   function automatic logic [27:0] model(input logic [7:0] r, g, b,
                                         input logic h, v, d, input logic [1:0] m);
      logic [6:0] e0, e1, e2, e3;
      if (m == 2'b10) begin
         e0 = {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
         e1 = {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
         e2 = {b[2], b[3], b[4], b[5], h, v, d};
         e3 = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
      end else begin
         e0 = {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
         e1 = {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
         e2 = {b[4], b[5], b[6], b[7], h, v, d};
         e3 = (m == 2'b01) ? {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0} : 7'd0;
      end
      return {e3, e2, e1, e0};
   endfunction

   // drive one pixel at the ready edge and check its seven slots
   task automatic send_check(input logic [7:0] r, g, b, input logic h, v, d,
                             input logic [1:0] m, input logic mr,
                             input bit scramble, input string tag);
      logic [27:0] w;
      int          se;
      logic [3:0]  exp;
      while (!ready) @(negedge clk);
      red = r; grn = g; blu = b; hs = h; vs = v; de = d; mode = m; mir = mr;
      w = model(r, g, b, h, v, d, m);
      for (int s = 0; s < 7; s++) begin
         @(negedge clk);
         if (scramble && s == 3) begin
            red = ~r; grn = ~g; blu = ~b; hs = ~h; vs = ~v; de = ~d;
            mode = m ^ 2'b01; mir = ~mr;
         end
         se  = mr ? 6 - s : s;
         exp = {w[21+se], w[14+se], w[7+se], w[se]};
         chk(lane_data == exp, tag, 32'(lane_data), 32'(exp));
         chk(lane_clk == !(s >= 2 && s <= 4), "R1 clock lane", 32'(lane_clk),
             32'(!(s >= 2 && s <= 4)));
      end
   endtask

   task automatic test_reset_state;
      chk(lane_data == 4'b0, "R10 lanes in reset", 32'(lane_data), 0);
      chk(ready == 1'b0, "R10 ready in reset", 32'(ready), 0);
      chk(lane_clk == 1'b1, "R10 clock lane in reset", 32'(lane_clk), 1);
   endtask

   task automatic test_ready_spacing;
      int n;
      while (!ready) @(negedge clk);
      @(negedge clk);
      chk(ready == 1'b0, "R2 ready width", 32'(ready), 0);
      n = 1;
      while (!ready && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(n == 7, "R2 ready period", 32'(n), 7);
   endtask

   task automatic test_mid_reset;
      while (!ready) @(negedge clk);
      red = 8'hFF; grn = 8'hFF; blu = 8'hFF; hs = 1; vs = 1; de = 1; mode = 2'b01;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      test_reset_state();
      rst = 1'b0;
      // first frame after reset carries the cleared pixel: all zeros
      for (int s = 0; s < 7; s++) begin
         chk(lane_data == 4'b0, "R10 first frame zero", 32'(lane_data), 0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset_state();
      rst = 1'b0;
      test_ready_spacing();
      send_check(8'hA5, 8'h3C, 8'hC3, 1, 0, 1, 2'b00, 0, 0, "R3 narrow map");
      send_check(8'h5A, 8'hC3, 8'h3C, 0, 1, 0, 2'b00, 0, 0, "R3 narrow map alt");
      send_check(8'h81, 8'h42, 8'h24, 1, 1, 1, 2'b01, 0, 0, "R4 wide-A map");
      send_check(8'h7E, 8'hBD, 8'hDB, 0, 0, 1, 2'b01, 0, 0, "R4 wide-A map alt");
      send_check(8'h96, 8'h69, 8'hF0, 1, 0, 0, 2'b10, 0, 0, "R5 wide-B map");
      send_check(8'h0F, 8'hE1, 8'h1E, 0, 1, 1, 2'b10, 0, 0, "R5 wide-B map alt");
      send_check(8'hA5, 8'h3C, 8'hC3, 1, 0, 1, 2'b11, 0, 0, "R6 alias mode");
      send_check(8'h00, 8'h00, 8'h00, 1, 0, 0, 2'b01, 0, 0, "R7 hsync slot");
      send_check(8'h00, 8'h00, 8'h00, 0, 1, 0, 2'b10, 0, 0, "R7 vsync slot");
      send_check(8'h00, 8'h00, 8'h00, 0, 0, 1, 2'b00, 0, 0, "R7 enable slot");
      send_check(8'h81, 8'h42, 8'h24, 1, 1, 0, 2'b01, 1, 0, "R8 mirror wide-A");
      send_check(8'h96, 8'h69, 8'hF0, 0, 1, 1, 2'b10, 1, 0, "R8 mirror wide-B");
      send_check(8'hA5, 8'h3C, 8'hC3, 1, 0, 1, 2'b00, 1, 0, "R8 mirror narrow");
      send_check(8'hC6, 8'h39, 8'hAA, 1, 0, 1, 2'b01, 0, 1, "R9 hold during frame");
      send_check(8'h55, 8'h99, 8'h66, 0, 1, 1, 2'b10, 1, 1, "R9 hold mirror");
      send_check(8'hAB, 8'h57, 8'hFF, 1, 1, 1, 2'b00, 0, 0, "R11 low bits ignored");
      send_check(8'hA8, 8'h54, 8'hFC, 1, 1, 1, 2'b00, 0, 0, "R11 low bits cleared");
      test_mid_reset();
      send_check(8'h12, 8'h34, 8'h56, 0, 1, 0, 2'b01, 0, 0, "R4 after reset");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule